// File: doc/BRIEF.md
# Serial Control Latch Driver

The block keeps an 8-bit board-control word in a local shadow register and copies it into an external shift-and-store latch over three wires: a serial clock, a serial data line and a strobe. The word carries these board controls, from bit 0 to bit 7:

- bit 0: internal-clock select for serial port 0
- bit 1: internal-clock select for serial port 1
- bit 2: active-low DTR for port 0
- bit 3: active-low DTR for port 1
- bit 4: a spare external control
- bit 5: auto-reset
- bit 6: active-low PCI reset
- bit 7: active-low EEPROM write-control

Software-side logic changes single bits with set and clear request vectors. It then issues an update command, and the block replays the whole word, most significant bit first.

The serial clock and data wires are shared with a two-wire bus. Between transfers the block holds clock and data high and strobe low, so another master can issue a START at any time. Every line change is followed by a settle delay of `SETTLE_CYC` system clocks. `busy` covers the whole transfer, and `done` pulses once at its end.

The sequencer has these states:

- `S_IDLE`: the lines rest.
- `S_CLK_LO`, `S_DAT`, `S_CLK_HI`: these repeat once per bit.
- `S_STB_HI`, `S_STB_LO`: the strobe pulse.
- `S_END_CLK_LO`, `S_END_DAT`, `S_END_CLK_HI`: the return to bus idle.

The state machine moves through them as follows:

- It leaves `S_IDLE` for `S_CLK_LO` when an update is requested or pending.
- Every other state advances when its settle time expires.
- `S_CLK_HI` goes back to `S_CLK_LO` while bits remain, and goes to `S_STB_HI` after bit 0.
- `S_STB_HI` is followed by `S_STB_LO`, then `S_END_CLK_LO`, `S_END_DAT`, `S_END_CLK_HI`, and finally `S_IDLE`.

Top module: `ctl_latch_drv`

## Requirements
- R1: During reset, ser_clk=1, ser_dat=1, ser_stb=0 and busy=0. The shadow resets to 8'hCC, which sets bits 2, 3, 6 and 7. One transfer of that value starts by itself on the first clock edge after reset is released.
- R2: A set or clear request changes only the addressed shadow bits and starts no transfer. If one bit is both set and cleared in the same cycle, set wins.
- R3: An update copies the shadow value captured at acceptance into the latch, most significant bit first. A latch that samples data on each rising ser_clk and loads its outputs on the rising ser_stb then holds exactly that value.
- R4: For each bit, the lines change in this order: ser_clk falls, then ser_dat takes the bit, then ser_clk rises. ser_dat never changes while ser_clk is high.
- R5: One strobe pulse per transfer, high then low, rising only after exactly 8 rising ser_clk edges of that transfer.
- R6: After the strobe, ser_clk falls, ser_dat goes high and ser_clk rises. The result is 9 rising ser_clk edges per transfer, and the lines idle at clk=1, dat=1, stb=0.
- R7: Successive line changes are at least SETTLE_CYC clocks apart. busy stays high for exactly (3*WIDTH+5)*SETTLE_CYC clocks per transfer.
- R8: An update that arrives while busy is held pending. Any number of such updates causes exactly one more transfer, which carries the latest shadow value.
- R9: done is a one-cycle pulse in the first cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_req | input | WIDTH | Per-bit set requests for the shadow word |
| clr_req | input | WIDTH | Per-bit clear requests for the shadow word |
| update | input | 1 | Request a transfer of the shadow word |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| ser_clk | output | 1 | Serial clock to the latch, shared with the two-wire bus |
| ser_dat | output | 1 | Serial data to the latch, shared with the two-wire bus |
| ser_stb | output | 1 | Storage strobe to the latch |

## Verification
An update presented at a falling edge is accepted at the next rising edge. `busy` is then seen at the following falling edge, and `done` follows (3*WIDTH+5)*SETTLE_CYC cycles later, in the same cycle as `busy` falls. Both the bench and its monitors sample only at falling edges, away from the edges where the block changes its outputs. The latch model reacts to line edges, and its value is compared only after `done` is seen. The spacing between line changes, the clock-edge count at each strobe and the idle state at `done` are checked at every transfer by monitors. Their totals are reported at the end.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CLK_LO,
        S_DAT,
        S_CLK_HI,
        S_STB_HI,
        S_STB_LO,
        S_END_CLK_LO,
        S_END_DAT,
        S_END_CLK_HI
    } seq_state_t;
endpackage

// File: rtl/ctl_settle_timer.sv
module ctl_settle_timer #(
    parameter int SETTLE_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(SETTLE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || expired)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R7
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < SETTLE_CYC);
endmodule

// File: rtl/ctl_shadow_bank.sv
module ctl_shadow_bank #(
    parameter int               WIDTH      = 8,
    parameter logic [WIDTH-1:0] INIT_VALUE = 8'hCC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_req,
    input  logic [WIDTH-1:0] clr_req,
    input  logic             update,
    input  logic             accept,
    output logic [WIDTH-1:0] shadow,
    output logic             pending
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow  <= INIT_VALUE;
            pending <= 1'b1;
        end else begin
            shadow  <= (shadow & ~clr_req) | set_req;
            pending <= accept ? 1'b0 : (pending | update);
        end
    end

    // R2
    bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req == '0 && clr_req == '0) |=> $stable(shadow));
endmodule

// File: rtl/ctl_shift_seq.sv
module ctl_shift_seq import ctl_latch_pkg::*; #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [WIDTH-1:0] shadow,
    input  logic             step_done,
    output logic             accept,
    output logic             run,
    output logic             done,
    output logic             ser_clk,
    output logic             ser_dat,
    output logic             ser_stb
);
    localparam int IW = (WIDTH < 2) ? 1 : $clog2(WIDTH);

    seq_state_t       state_q, state_nxt;
    logic [IW-1:0]    idx_q;
    logic [WIDTH-1:0] snap_q;

    assign accept = (state_q == S_IDLE) && req;
    assign run    = (state_q != S_IDLE);

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            S_IDLE:       if (req)       state_nxt = S_CLK_LO;
            S_CLK_LO:     if (step_done) state_nxt = S_DAT;
            S_DAT:        if (step_done) state_nxt = S_CLK_HI;
            S_CLK_HI:     if (step_done) state_nxt = (idx_q == '0) ? S_STB_HI : S_CLK_LO;
            S_STB_HI:     if (step_done) state_nxt = S_STB_LO;
            S_STB_LO:     if (step_done) state_nxt = S_END_CLK_LO;
            S_END_CLK_LO: if (step_done) state_nxt = S_END_DAT;
            S_END_DAT:    if (step_done) state_nxt = S_END_CLK_HI;
            S_END_CLK_HI: if (step_done) state_nxt = S_IDLE;
            default:                     state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            snap_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (accept) begin
                idx_q  <= IW'(WIDTH - 1);
                snap_q <= shadow;
            end else if (state_q == S_CLK_HI && step_done && idx_q != '0) begin
                idx_q  <= idx_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_clk <= 1'b1;
            ser_dat <= 1'b1;
            ser_stb <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= (state_q == S_END_CLK_HI) && step_done;
            unique case (state_nxt)
                S_CLK_LO, S_END_CLK_LO: ser_clk <= 1'b0;
                S_CLK_HI, S_END_CLK_HI: ser_clk <= 1'b1;
                S_DAT:                  ser_dat <= snap_q[idx_q];
                S_END_DAT:              ser_dat <= 1'b1;
                S_STB_HI:               ser_stb <= 1'b1;
                S_STB_LO:               ser_stb <= 1'b0;
                default:                ;
            endcase
        end
    end

    // R4
    dat_moves_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dat) |-> (!ser_clk && !$past(ser_clk)));

    // R6
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (ser_clk && ser_dat && !ser_stb));

    // R5
    stb_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_stb) |-> ($past(state_q) == S_CLK_HI && idx_q == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/ctl_latch_drv.sv
module ctl_latch_drv #(
    parameter int               WIDTH      = 8,
    parameter int               SETTLE_CYC = 300,
    parameter logic [WIDTH-1:0] INIT_VALUE = 8'hCC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_req,
    input  logic [WIDTH-1:0] clr_req,
    input  logic             update,
    output logic             busy,
    output logic             done,
    output logic             ser_clk,
    output logic             ser_dat,
    output logic             ser_stb
);
    logic [WIDTH-1:0] shadow;
    logic             pending;
    logic             accept;
    logic             run;
    logic             step_done;

    ctl_shadow_bank #(.WIDTH(WIDTH), .INIT_VALUE(INIT_VALUE)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .update  (update),
        .accept  (accept),
        .shadow  (shadow),
        .pending (pending)
    );

    ctl_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .expired (step_done)
    );

    ctl_shift_seq #(.WIDTH(WIDTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (pending | update),
        .shadow    (shadow),
        .step_done (step_done),
        .accept    (accept),
        .run       (run),
        .done      (done),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_stb   (ser_stb)
    );

    assign busy = run;
endmodule

// File: tb/ctl_latch_drv_tb.sv
module ctl_latch_drv_tb;
    localparam int W     = 8;
    localparam int S     = 4;
    localparam int STEPS = (3 * W + 5) * S;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] set_req = '0;
    logic [W-1:0] clr_req = '0;
    logic         update = 1'b0;
    logic         busy, done, ser_clk, ser_dat, ser_stb;

    always #5 clk = ~clk;

    ctl_latch_drv #(.WIDTH(W), .SETTLE_CYC(S), .INIT_VALUE(8'hCC)) u_dut (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
        .update(update), .busy(busy), .done(done),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_stb(ser_stb)
    );

    // external latch model
    logic [W-1:0] shf = '0;
    logic [W-1:0] lat = '0;
    always @(posedge ser_clk) shf <= {shf[W-2:0], ser_dat};
    always @(posedge ser_stb) lat <= shf;

    // {set, clr, expected latch}
    localparam logic [23:0] VEC [6] = '{
        24'h01_00_CD, 24'h30_0C_F1, 24'h00_FF_00,
        24'hFF_00_FF, 24'h5A_FF_5A, 24'h00_42_18
    };

    int errors = 0, checks = 0;
    int gap = 1000, viol_gap = 0, viol_dat = 0, stb_bad = 0, end_bad = 0;
    int clk_rises = 0, stb_cnt = 0, busy_len = 0, last_busy_len = 0;
    int done_cnt = 0, done_wide = 0;
    logic p_clk = 1'b1, p_dat = 1'b1, p_stb = 1'b0, p_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ({ser_clk, ser_dat, ser_stb} != {p_clk, p_dat, p_stb}) begin
                if (gap < S - 1) viol_gap++;
                gap = 0;
            end else begin
                gap++;
            end
            if (ser_dat != p_dat && (ser_clk || p_clk)) viol_dat++;
            if (ser_clk && !p_clk) clk_rises++;
            if (ser_stb && !p_stb) begin
                if (clk_rises != 8) stb_bad++;
                stb_cnt++;
            end
            if (busy) busy_len++;
            if (done) begin
                last_busy_len = busy_len;
                busy_len = 0;
                done_cnt++;
                if (clk_rises != 9 || stb_cnt != 1 || !ser_clk || !ser_dat || ser_stb || busy)
                    end_bad++;
                clk_rises = 0;
                stb_cnt = 0;
                if (p_done) done_wide++;
            end
            p_done = done;
            p_clk = ser_clk; p_dat = ser_dat; p_stb = ser_stb;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_bits(input logic [W-1:0] s, input logic [W-1:0] c);
        @(negedge clk); set_req = s; clr_req = c;
        @(negedge clk); set_req = '0; clr_req = '0;
    endtask

    task automatic pulse_update();
        @(negedge clk); update = 1'b1;
        @(negedge clk); update = 1'b0;
    endtask

    task automatic wait_done(input int target);
        for (int n = 0; n < 2000 && done_cnt < target; n++) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        check(ser_clk && ser_dat && !ser_stb, "R1 reset lines", {ser_clk, ser_dat, ser_stb}, 3'b110);
        check(!busy, "R1 reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy, "R1 auto transfer starts", busy, 1);
        wait_done(1);
        @(negedge clk);
        check(lat == 8'hCC, "R1 init latch value", lat, 8'hCC);
        check(last_busy_len == STEPS, "R7 busy length", last_busy_len, STEPS);

        for (int v = 0; v < 6; v++) begin
            d0 = done_cnt;
            pulse_bits(VEC[v][23:16], VEC[v][15:8]);
            pulse_update();
            wait_done(d0 + 1);
            @(negedge clk);
            check(lat == VEC[v][7:0], "R3 R2 latch after update", lat, VEC[v][7:0]);
            check(last_busy_len == STEPS, "R7 busy length per transfer", last_busy_len, STEPS);
        end

        // R2: a request without update leaves the latch alone
        d0 = done_cnt;
        pulse_bits(8'h80, 8'h00);
        repeat (100) @(negedge clk);
        check(done_cnt == d0 && !busy, "R2 no transfer without update", done_cnt, d0);
        check(lat == 8'h18, "R2 latch unchanged", lat, 8'h18);

        // R8: updates while busy collapse into one more transfer
        d0 = done_cnt;
        pulse_update();
        repeat (20) @(negedge clk);
        check(busy, "R8 busy during transfer", busy, 1);
        pulse_bits(8'h01, 8'h00);
        pulse_update();
        pulse_update();
        wait_done(d0 + 1);
        @(negedge clk);
        check(lat == 8'h98, "R8 first transfer value", lat, 8'h98);
        wait_done(d0 + 2);
        @(negedge clk);
        check(lat == 8'h99, "R8 pending transfer latest value", lat, 8'h99);
        repeat (300) @(negedge clk);
        check(done_cnt == d0 + 2, "R8 single extra transfer", done_cnt, d0 + 2);

        check(viol_gap == 0, "R7 settle spacing", viol_gap, 0);
        check(viol_dat == 0, "R4 data moves with clock low", viol_dat, 0);
        check(stb_bad == 0, "R5 strobe after 8 clock edges", stb_bad, 0);
        check(end_bad == 0, "R6 end sequence and idle lines", end_bad, 0);
        check(done_wide == 0, "R9 done one cycle", done_wide, 0);
        finish_run();
    end
endmodule